// File: doc/BRIEF.md
# Memory-Mapped Chip-Select Decoder

This block connects an 8-bit processor bus with a 16-bit address to a small set of on-chip memory devices. Each cycle it looks at the upper address bits, together with a valid-access qualifier, and picks at most one device. It drives that device's active-low chip select and passes the device its local offset taken from the low address bits. Read data from the chosen device comes back on an 8-bit bus. Writes reach RAM devices only.

A parameter chooses between two fixed memory maps. Map 0 holds a 2 KB RAM at 2000h and a 4 KB ROM at A000h. The two devices decode different numbers of upper bits, and the rest of the space is left unmapped. Map 1 holds eight 2 KB RAM banks that fill 0000h–3FFFh. A 3-to-8 stage selects among them, and that stage is enabled only for the low 16 KB and only while the access is valid. Every request is handled in one synchronous cycle. Chip selects, the device offset and read data all appear one clock after the request.

Top module: `cs_decode_top`

## Requirements
- R1: While reset is high, and in the cycle after it, every chip select is high, the device offset is 0 and the read data is FFh.
- R2: With map 0, a valid access whose address bits 15..11 equal 00100b (2000h–27FFh) drives cs_n[0] low on the next cycle. The device offset is then address bits 10..0, zero-extended to 12 bits.
- R3: With map 0, a valid access whose address bits 15..12 equal 1010b (A000h–AFFFh) drives cs_n[1] low on the next cycle. The device offset is then address bits 11..0.
- R4: At most one chip select is low in any cycle. Unmapped addresses leave all selects high with offset 0. With map 0, cs_n[7:2] are always high.
- R5: When the valid-access input is low, no chip select goes low and a write changes no stored byte.
- R6: With map 1, a valid access below 4000h drives cs_n[k] low, where k = address bits 13..11 (bit 11 is the least significant). The offset is address bits 10..0. Addresses 4000h–FFFFh select nothing.
- R7: A valid write to a RAM address stores the data byte, and a later read of the same address returns it.
- R8: A write to a ROM address or to an unmapped address changes no stored byte.
- R9: Read data is valid one cycle after a read request. It is FFh when the previous cycle had no read, or had a read that selected no device.
- R10: The ROM byte at offset o (0..FFFh) is (o[7:0] XOR {4'h0, o[11:8]} XOR 5Ah). This gives 5Ah at A000h, AAh at AFFFh and 78h at A123h.
- R11: With map 1, the eight banks hold separate storage. A write to one bank leaves the same offset in the other banks unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 16 | Processor address |
| vma | input | 1 | Valid-access qualifier, active high |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| cs_n | output | 8 | Registered active-low chip selects |
| dev_addr | output | 12 | Registered local offset for the selected device |
| rdata | output | 8 | Read data, FFh when idle or unmapped |

## Verification
The assertions check the following on every cycle:
- the select pattern has at most one bit low;
- a low qualifier forces every select high;
- the select and offset for each decoded range, one cycle later;
- that map 0 never drives the unused selects;
- the FFh idle value after a cycle with no read.

Only the bench's scenarios can show the behaviour of stored data:
- RAM writes read back correctly;
- writes are ignored when aimed at the ROM, at holes, or made with the qualifier low;
- the banks stay separate;
- the ROM table holds the right bytes at its boundaries.

The bench also sweeps the first, last, one-below and one-above address of every range.

// File: rtl/cs_map_pkg.sv
package cs_map_pkg;

  // Fixed placement of the map-0 devices
  localparam logic [15:0] MAP0_RAM_BASE = 16'h2000;
  localparam logic [15:0] MAP0_ROM_BASE = 16'hA000;

  // ROM fill pattern, a function of the byte offset
  function automatic logic [7:0] rom_word(input logic [15:0] off);
    return off[7:0] ^ {4'h0, off[11:8]} ^ 8'h5A;
  endfunction

endpackage

// File: rtl/cs_line_decoder.sv
module cs_line_decoder #(
  parameter int SEL_W = 3,
  localparam int NOUT = 1 << SEL_W
) (
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  output logic [NOUT-1:0]  y_n
);

  for (genvar i = 0; i < NOUT; i++) begin : g_line
    assign y_n[i] = !(en && (sel == SEL_W'(i)));
  end

endmodule

// File: rtl/cs_addr_decoder.sv
module cs_addr_decoder
  import cs_map_pkg::*;
#(
  parameter int MAP_SEL = 0,
  parameter int ADDR_W  = 16,
  parameter int NUM_CS  = 8,
  parameter int RAM_AW  = 11,
  parameter int ROM_AW  = 12,
  localparam int DEV_AW = (ROM_AW > RAM_AW) ? ROM_AW : RAM_AW
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              vma,
  output logic [NUM_CS-1:0] cs_n,
  output logic [DEV_AW-1:0] dev_addr
);

  if (MAP_SEL == 0) begin : g_sparse
    logic sel_ram, sel_rom;
    // Devices of different size compare different numbers of upper bits
    assign sel_ram = vma && (addr[ADDR_W-1:RAM_AW] == MAP0_RAM_BASE[ADDR_W-1:RAM_AW]);
    assign sel_rom = vma && (addr[ADDR_W-1:ROM_AW] == MAP0_ROM_BASE[ADDR_W-1:ROM_AW]);

    always_comb begin
      cs_n    = '1;
      cs_n[0] = !sel_ram;
      cs_n[1] = !sel_rom;
      if (sel_ram)      dev_addr = DEV_AW'(addr[RAM_AW-1:0]);
      else if (sel_rom) dev_addr = DEV_AW'(addr[ROM_AW-1:0]);
      else              dev_addr = '0;
    end
  end else begin : g_banked
    localparam int SW = $clog2(NUM_CS);
    logic en;
    // Enable gating: qualifier high and all bits above the bank field zero
    assign en = vma && (addr[ADDR_W-1:RAM_AW+SW] == '0);

    cs_line_decoder #(.SEL_W(SW)) u_line (
      .en  (en),
      .sel (addr[RAM_AW +: SW]),
      .y_n (cs_n)
    );

    assign dev_addr = en ? DEV_AW'(addr[RAM_AW-1:0]) : '0;
  end

endmodule

// File: rtl/cs_ram_bank.sv
module cs_ram_bank #(
  parameter int AW = 11,
  parameter int DW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  // Read-first synchronous port, suited to block RAM inference
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end

endmodule

// File: rtl/cs_rom.sv
module cs_rom
  import cs_map_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = DW'(rom_word(16'(i)));
  end

  always_ff @(posedge clk) rdata <= mem[addr];

endmodule

// File: rtl/cs_decode_top.sv
module cs_decode_top #(
  parameter int MAP_SEL = 0,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int NUM_CS  = 8,
  parameter int RAM_AW  = 11,
  parameter int ROM_AW  = 12,
  localparam int DEV_AW = (ROM_AW > RAM_AW) ? ROM_AW : RAM_AW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              vma,
  input  logic              rd,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [NUM_CS-1:0] cs_n,
  output logic [DEV_AW-1:0] dev_addr,
  output logic [DATA_W-1:0] rdata
);

  logic [NUM_CS-1:0] cs_n_d, cs_n_q;
  logic [DEV_AW-1:0] da_d, da_q;
  logic              rd_hit_q;
  logic [DATA_W-1:0] dev_q [NUM_CS];

  cs_addr_decoder #(
    .MAP_SEL (MAP_SEL),
    .ADDR_W  (ADDR_W),
    .NUM_CS  (NUM_CS),
    .RAM_AW  (RAM_AW),
    .ROM_AW  (ROM_AW)
  ) u_dec (
    .addr     (addr),
    .vma      (vma),
    .cs_n     (cs_n_d),
    .dev_addr (da_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_n_q   <= '1;
      da_q     <= '0;
      rd_hit_q <= 1'b0;
    end else begin
      cs_n_q   <= cs_n_d;
      da_q     <= da_d;
      rd_hit_q <= rd && !(&cs_n_d);
    end
  end

  if (MAP_SEL == 0) begin : g_map0
    cs_ram_bank #(.AW(RAM_AW), .DW(DATA_W)) u_ram (
      .clk   (clk),
      .we    (wr && !cs_n_d[0]),
      .addr  (addr[RAM_AW-1:0]),
      .wdata (wdata),
      .rdata (dev_q[0])
    );
    cs_rom #(.AW(ROM_AW), .DW(DATA_W)) u_rom (
      .clk   (clk),
      .addr  (addr[ROM_AW-1:0]),
      .rdata (dev_q[1])
    );
    for (genvar k = 2; k < NUM_CS; k++) begin : g_fill
      assign dev_q[k] = '1;
    end
  end else begin : g_map1
    for (genvar k = 0; k < NUM_CS; k++) begin : g_bank
      cs_ram_bank #(.AW(RAM_AW), .DW(DATA_W)) u_ram (
        .clk   (clk),
        .we    (wr && !cs_n_d[k]),
        .addr  (addr[RAM_AW-1:0]),
        .wdata (wdata),
        .rdata (dev_q[k])
      );
    end
  end

  // Read steering: AND-OR over the one-hot registered selects
  always_comb begin
    logic [DATA_W-1:0] acc;
    acc = '0;
    for (int k = 0; k < NUM_CS; k++) begin
      if (!cs_n_q[k]) acc = acc | dev_q[k];
    end
    rdata = rd_hit_q ? acc : '1;
  end

  assign cs_n     = cs_n_q;
  assign dev_addr = da_q;

endmodule

// File: rtl/cs_decode_chk.sv
module cs_decode_chk
  import cs_map_pkg::*;
#(
  parameter int MAP_SEL = 0,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int NUM_CS  = 8,
  parameter int RAM_AW  = 11,
  parameter int DEV_AW  = 12
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              vma,
  input logic              rd,
  input logic [NUM_CS-1:0] cs_n,
  input logic [DEV_AW-1:0] dev_addr,
  input logic [DATA_W-1:0] rdata
);

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (&cs_n && dev_addr == '0 && rdata == '1));

  assert_one_select_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cs_n));

  assert_vma_gate_R5: assert property (@(posedge clk) disable iff (rst)
    !vma |=> &cs_n);

  assert_idle_read_R9: assert property (@(posedge clk) disable iff (rst)
    !rd |=> rdata == '1);

  if (MAP_SEL == 0) begin : g_m0
    assert_ram_select_R2: assert property (@(posedge clk) disable iff (rst)
      (vma && addr[15:11] == MAP0_RAM_BASE[15:11])
      |=> (!cs_n[0] && dev_addr == DEV_AW'($past(addr[10:0]))));

    assert_rom_select_R3: assert property (@(posedge clk) disable iff (rst)
      (vma && addr[15:12] == MAP0_ROM_BASE[15:12])
      |=> (!cs_n[1] && dev_addr == $past(addr[11:0])));

    assert_spare_high_R4: assert property (@(posedge clk) disable iff (rst)
      &cs_n[NUM_CS-1:2]);
  end else begin : g_m1
    localparam int SW = $clog2(NUM_CS);

    assert_bank_select_R6: assert property (@(posedge clk) disable iff (rst)
      (vma && addr[ADDR_W-1:RAM_AW+SW] == '0)
      |=> (!cs_n[$past(addr[RAM_AW +: SW])] &&
           dev_addr == DEV_AW'($past(addr[RAM_AW-1:0]))));

    assert_high_space_idle_R6: assert property (@(posedge clk) disable iff (rst)
      (addr[ADDR_W-1:RAM_AW+SW] != '0) |=> (&cs_n && dev_addr == '0));
  end

endmodule

bind cs_decode_top cs_decode_chk #(
  .MAP_SEL (MAP_SEL),
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .NUM_CS  (NUM_CS),
  .RAM_AW  (RAM_AW),
  .DEV_AW  (DEV_AW)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .addr     (addr),
  .vma      (vma),
  .rd       (rd),
  .cs_n     (cs_n),
  .dev_addr (dev_addr),
  .rdata    (rdata)
);

// File: tb/cs_decode_top_tb.sv
`timescale 1ns/1ps
module cs_decode_top_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] addr = '0;
  logic        vma = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [7:0]  wdata = '0;

  logic [7:0]  cs0, cs1, rdata0, rdata1;
  logic [11:0] da0, da1;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  cs_decode_top #(.MAP_SEL(0)) u_dut (
    .clk(clk), .rst(rst), .addr(addr), .vma(vma), .rd(rd), .wr(wr),
    .wdata(wdata), .cs_n(cs0), .dev_addr(da0), .rdata(rdata0));

  cs_decode_top #(.MAP_SEL(1)) u_dut_m1 (
    .clk(clk), .rst(rst), .addr(addr), .vma(vma), .rd(rd), .wr(wr),
    .wdata(wdata), .cs_n(cs1), .dev_addr(da1), .rdata(rdata1));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One bus cycle: drive at the falling edge, sample just after the rising edge
  task automatic bus(input logic [15:0] a, input logic v, input logic r,
                     input logic w, input logic [7:0] d);
    @(negedge clk);
    addr = a; vma = v; rd = r; wr = w; wdata = d;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [7:0] exp_cs0(input logic [15:0] a, input logic v);
    logic [7:0] c;
    c = '1;
    if (v && a[15:11] == 5'b00100) c[0] = 1'b0;
    else if (v && a[15:12] == 4'b1010) c[1] = 1'b0;
    return c;
  endfunction

  function automatic logic [11:0] exp_da0(input logic [15:0] a);
    if (a[15:11] == 5'b00100) return {1'b0, a[10:0]};
    if (a[15:12] == 4'b1010)  return a[11:0];
    return '0;
  endfunction

  function automatic logic [7:0] exp_cs1(input logic [15:0] a, input logic v);
    logic [7:0] c;
    c = '1;
    if (v && a[15:14] == 2'b00) c[a[13:11]] = 1'b0;
    return c;
  endfunction

  function automatic logic [11:0] exp_da1(input logic [15:0] a);
    return (a[15:14] == 2'b00) ? {1'b0, a[10:0]} : 12'h000;
  endfunction

  task automatic t_reset();
    chk("R1 cs map0", cs0, 8'hFF);
    chk("R1 cs map1", cs1, 8'hFF);
    chk("R1 offset", {da0, da1}, 24'h0);
    chk("R1 rdata", {rdata0, rdata1}, 16'hFFFF);
  endtask

  task automatic t_sweep_map0();
    logic [15:0] pts [11] = '{16'h0000, 16'h1FFF, 16'h2000, 16'h2001, 16'h27FF,
                              16'h2800, 16'h9FFF, 16'hA000, 16'hAFFF, 16'hB000, 16'hFFFF};
    foreach (pts[i]) begin
      bus(pts[i], 1'b1, 1'b1, 1'b0, 8'h00);
      chk("R2/R3/R4 map0 select", cs0, exp_cs0(pts[i], 1'b1));
      chk("R2/R3 map0 offset", da0, exp_da0(pts[i]));
      if (&exp_cs0(pts[i], 1'b1)) chk("R9 unmapped read", rdata0, 8'hFF);
    end
  endtask

  task automatic t_sweep_map1();
    for (int k = 0; k < 8; k++) begin
      logic [15:0] lo, hi;
      lo = 16'(k * 16'h0800);
      hi = lo + 16'h07FF;
      bus(lo, 1'b1, 1'b1, 1'b0, 8'h00);
      chk("R6 bank first select", cs1, exp_cs1(lo, 1'b1));
      chk("R6 bank first offset", da1, exp_da1(lo));
      bus(hi, 1'b1, 1'b1, 1'b0, 8'h00);
      chk("R6 bank last select", cs1, exp_cs1(hi, 1'b1));
      chk("R6 bank last offset", da1, exp_da1(hi));
    end
    bus(16'h4000, 1'b1, 1'b1, 1'b0, 8'h00);
    chk("R6 above banks", cs1, 8'hFF);
    chk("R9 above banks read", rdata1, 8'hFF);
    bus(16'hFFFF, 1'b1, 1'b1, 1'b0, 8'h00);
    chk("R6 top of space", cs1, 8'hFF);
  endtask

  task automatic t_ram_rw();
    bus(16'h2000, 1'b1, 1'b0, 1'b1, 8'hA5);
    bus(16'h27FF, 1'b1, 1'b0, 1'b1, 8'h3C);
    bus(16'h2000, 1'b1, 1'b1, 1'b0, 8'h00);
    chk("R7 map0 first byte", rdata0, 8'hA5);
    chk("R7 map1 bank4 first", rdata1, 8'hA5);
    bus(16'h27FF, 1'b1, 1'b1, 1'b0, 8'h00);
    chk("R7 map0 last byte", rdata0, 8'h3C);
    bus(16'h0000, 1'b1, 1'b0, 1'b1, 8'h11);
    bus(16'h3FFF, 1'b1, 1'b0, 1'b1, 8'hEE);
    bus(16'h0000, 1'b1, 1'b1, 1'b0, 8'h00);
    chk("R7 map1 bank0", rdata1, 8'h11);
    bus(16'h3FFF, 1'b1, 1'b1, 1'b0, 8'h00);
    chk("R7 map1 bank7", rdata1, 8'hEE);
  endtask

  task automatic t_vma_gate();
    bus(16'h2100, 1'b1, 1'b0, 1'b1, 8'h11);
    bus(16'h2100, 1'b0, 1'b1, 1'b1, 8'h33);
    chk("R5 no select map0", cs0, 8'hFF);
    chk("R5 no select map1", cs1, 8'hFF);
    chk("R5 read gated", rdata0, 8'hFF);
    bus(16'h2100, 1'b1, 1'b1, 1'b0, 8'h00);
    chk("R5 write ignored map0", rdata0, 8'h11);
    chk("R5 write ignored map1", rdata1, 8'h11);
  endtask

  task automatic t_rom_and_holes();
    bus(16'hA000, 1'b1, 1'b1, 1'b0, 8'h00);
    chk("R10 rom first", rdata0, 8'h5A);
    bus(16'hAFFF, 1'b1, 1'b1, 1'b0, 8'h00);
    chk("R10 rom last", rdata0, 8'hAA);
    bus(16'hA123, 1'b1, 1'b1, 1'b0, 8'h00);
    chk("R10 rom middle", rdata0, 8'h78);
    bus(16'hA000, 1'b1, 1'b0, 1'b1, 8'h00);
    bus(16'hA000, 1'b1, 1'b1, 1'b0, 8'h00);
    chk("R8 rom write ignored", rdata0, 8'h5A);
    bus(16'h4100, 1'b1, 1'b0, 1'b1, 8'h77);
    bus(16'h2100, 1'b1, 1'b1, 1'b0, 8'h00);
    chk("R8 hole write ignored map0", rdata0, 8'h11);
    chk("R8 hole write ignored map1", rdata1, 8'h11);
  endtask

  task automatic t_read_timing();
    bus(16'h2100, 1'b1, 1'b0, 1'b0, 8'h00);
    chk("R9 no read idle", rdata0, 8'hFF);
    chk("R9 select without read", cs0, 8'hFE);
    bus(16'h2100, 1'b1, 1'b1, 1'b0, 8'h00);
    chk("R9 read next cycle", rdata0, 8'h11);
  endtask

  task automatic t_bank_isolation();
    for (int k = 0; k < 8; k++)
      bus(16'(k * 16'h0800 + 16'h0010), 1'b1, 1'b0, 1'b1, 8'(8'h40 + k));
    for (int k = 0; k < 8; k++) begin
      bus(16'(k * 16'h0800 + 16'h0010), 1'b1, 1'b1, 1'b0, 8'h00);
      chk("R11 bank data", rdata1, 32'(8'h40 + k));
      chk("R11 bank select", cs1, exp_cs1(16'(k * 16'h0800), 1'b1));
    end
  endtask

  initial begin
    #4000000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst = 1'b0;
    t_sweep_map0();
    t_sweep_map1();
    t_ram_rw();
    t_vma_gate();
    t_rom_and_holes();
    t_read_timing();
    t_bank_isolation();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule